// File: doc/BRIEF.md
# Real-Time Clock with Alarms and Stopwatch

The block keeps wall time from a slow 32.768 kHz clock. A divider turns that clock into a once-per-second strobe. The strobe advances a seconds / minutes / hours time of day and a free-running day count. There is no month or year calendar: the day count is a plain binary counter that wraps around. Each second, the block also compares the new time against two alarm settings. The daily alarm matches on time of day only. The dated alarm matches on both day and time of day. A one-second countdown timer raises an event when it runs out.

Software uses a small synchronous register port to set the time, program the alarms and the countdown, choose which events may interrupt, and clear sticky event flags. A newly written time does not show at once. The divider starts a fresh second, and the written value appears at the end of that second. The interrupt output is a level: it is the OR of the enabled flags. The wakeup output is a single-cycle pulse in the cycle after any enabled event fires.

Register map (word address on `wr_addr`/`rd_addr`):
- 0: time. Seconds in bits 5:0, minutes in bits 11:6, hours in bits 16:12, day from bit 17 upward.
- 1: daily alarm, with the same time-of-day fields.
- 2: dated alarm, with the same layout as the time register.
- 3: countdown value.
- 4: interrupt enable.
- 5: status.

Enable and status bits are assigned as follows:
- bit 0: second
- bit 1: minute rollover
- bit 2: hour rollover
- bit 3: day rollover
- bit 4: daily alarm
- bit 5: dated alarm
- bit 6: countdown underflow

Top module: `rtc_timekeeper`

## Requirements
- R1: The time advances by exactly one second every DIV clock cycles. Two seconds are never counted in adjacent cycles.
- R2: Seconds count modulo 60 and minutes modulo 60. Hours count modulo 24. The day count (DAY_W bits) wraps from its maximum back to 0. A field written out of range loads as 0.
- R3: A write to address 0 restarts the divider. The time read back keeps its old value for the next DIV-1 cycles. It becomes the written value on the DIV-th clock edge after the write edge, and it counts on from there. The load itself raises no rollover event.
- R4: Every counted second sets status bit 0. A seconds wrap also sets bit 1, a minutes wrap also sets bit 2, and an hours wrap also sets bit 3.
- R5: Status bit 4 is set when the new time of day equals the daily alarm, whatever the day.
- R6: Status bit 5 is set only when both the day and the time of day equal the dated alarm.
- R7: Writing address 3 loads and arms the countdown. Each second it decrements. A second that finds it at 0 sets status bit 6 and disarms it, and the value then stays at 0.
- R8: Writing ones to address 5 clears those status bits. Bits written with zero are kept, and an event in the same cycle wins over the clear.
- R9: `irq` is high exactly when a status bit is set whose matching bit in the enable register is also set.
- R10: `wakeup` is high for one cycle, the cycle after the edge at which an enabled event fires.
- R11: After reset the time, alarms, countdown, enables and status all read 0, and `irq` and `wakeup` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz timekeeping clock, also used for the register port |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register port |
| wr_addr | input | 3 | Word address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Word address of the combinational read |
| rd_data | output | 32 | Read data |
| irq | output | 1 | Level interrupt, the OR of the enabled status bits |
| wakeup | output | 1 | One-cycle pulse on any enabled event |

## Verification
A wrong divider or counter state shows up as a wrong time read at the very next once-per-second sample. Because that error is carried forward, every later second of the sweep differs from the arithmetic model. The bench uses a four-cycle second and a three-bit day count. It sweeps twenty consecutive seconds across a midnight that is also the day wrap, and compares time, `irq` and `wakeup` on every second. A faulty compare, countdown or flag-clear shows in the status word and in `irq` within one second of the event. The bench also checks the cycle just before a written time should appear.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NUM_EV  = 7;
  localparam int EV_SEC  = 0;
  localparam int EV_MIN  = 1;
  localparam int EV_HOUR = 2;
  localparam int EV_DAY  = 3;
  localparam int EV_AL1  = 4;
  localparam int EV_AL2  = 5;
  localparam int EV_SW   = 6;

  localparam int TOD_W   = 17;
  localparam int DAY_LSB = 17;

  localparam logic [2:0] A_TIME = 3'd0;
  localparam logic [2:0] A_AL1  = 3'd1;
  localparam logic [2:0] A_AL2  = 3'd2;
  localparam logic [2:0] A_SW   = 3'd3;
  localparam logic [2:0] A_IEN  = 3'd4;
  localparam logic [2:0] A_STAT = 3'd5;

  typedef struct packed {
    logic [4:0] hour;
    logic [5:0] min;
    logic [5:0] sec;
  } tod_t;

  function automatic tod_t tod_sanitize(input tod_t t);
    tod_t r;
    r.sec  = (t.sec  > 6'd59) ? 6'd0 : t.sec;
    r.min  = (t.min  > 6'd59) ? 6'd0 : t.min;
    r.hour = (t.hour > 5'd23) ? 5'd0 : t.hour;
    return r;
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (restart_i)          cnt_d = '0;
    else if (cnt_q == LAST) cnt_d = '0;
    else                    cnt_d = cnt_q + CW'(1);
  end

  assign tick_o = (cnt_q == LAST) && !restart_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R1
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);
endmodule

// File: rtl/rtc_time_counter.sv
module rtc_time_counter
  import rtc_pkg::*;
#(
  parameter int DAY_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             load_i,
  input  tod_t             load_tod_i,
  input  logic [DAY_W-1:0] load_day_i,
  output tod_t             tod_o,
  output logic [DAY_W-1:0] day_o,
  output tod_t             nxt_tod_o,
  output logic [DAY_W-1:0] nxt_day_o,
  output logic [3:0]       roll_o
);
  tod_t             tod_q, tod_d, ptod_q, ptod_d;
  logic [DAY_W-1:0] day_q, day_d, pday_q, pday_d;
  logic             pend_q, pend_d;
  tod_t             inc_tod;
  logic [DAY_W-1:0] inc_day;
  logic [3:0]       roll;

  always_comb begin
    inc_tod = tod_q;
    inc_day = day_q;
    roll    = 4'b0001;
    if (tod_q.sec >= 6'd59) begin
      inc_tod.sec = '0;
      roll[1]     = 1'b1;
      if (tod_q.min >= 6'd59) begin
        inc_tod.min = '0;
        roll[2]     = 1'b1;
        if (tod_q.hour >= 5'd23) begin
          inc_tod.hour = '0;
          roll[3]      = 1'b1;
          inc_day      = day_q + DAY_W'(1);
        end else begin
          inc_tod.hour = tod_q.hour + 5'd1;
        end
      end else begin
        inc_tod.min = tod_q.min + 6'd1;
      end
    end else begin
      inc_tod.sec = tod_q.sec + 6'd1;
    end
  end

  assign nxt_tod_o = pend_q ? tod_sanitize(ptod_q) : inc_tod;
  assign nxt_day_o = pend_q ? pday_q : inc_day;
  assign roll_o    = (tick_i && !pend_q) ? roll : 4'b0000;

  always_comb begin
    tod_d  = tod_q;
    day_d  = day_q;
    pend_d = pend_q;
    ptod_d = ptod_q;
    pday_d = pday_q;
    if (load_i) begin
      pend_d = 1'b1;
      ptod_d = load_tod_i;
      pday_d = load_day_i;
    end else if (tick_i) begin
      pend_d = 1'b0;
      tod_d  = nxt_tod_o;
      day_d  = nxt_day_o;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tod_q  <= '0;
      day_q  <= '0;
      pend_q <= 1'b0;
      ptod_q <= '0;
      pday_q <= '0;
    end else begin
      tod_q  <= tod_d;
      day_q  <= day_d;
      pend_q <= pend_d;
      ptod_q <= ptod_d;
      pday_q <= pday_d;
    end
  end

  assign tod_o = tod_q;
  assign day_o = day_q;

  // R2
  tod_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tod_q.sec < 6'd60) && (tod_q.min < 6'd60) && (tod_q.hour < 5'd24));
  // R3
  hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> ($stable(tod_q) && $stable(day_q)));
  // R4
  minute_roll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    roll_o[1] |=> (tod_q.sec == 6'd0));
endmodule

// File: rtl/rtc_stopwatch.sv
module rtc_stopwatch #(
  parameter int SW_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_i,
  input  logic            load_i,
  input  logic [SW_W-1:0] load_val_i,
  output logic [SW_W-1:0] cnt_o,
  output logic            underflow_o
);
  logic [SW_W-1:0] cnt_q, cnt_d;
  logic            armed_q, armed_d;

  assign underflow_o = tick_i && armed_q && (cnt_q == '0) && !load_i;

  always_comb begin
    cnt_d   = cnt_q;
    armed_d = armed_q;
    if (load_i) begin
      cnt_d   = load_val_i;
      armed_d = 1'b1;
    end else if (tick_i && armed_q) begin
      if (cnt_q == '0) armed_d = 1'b0;
      else             cnt_d   = cnt_q - SW_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
    end
  end

  assign cnt_o = cnt_q;

  // R7
  countdown_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && armed_q && (cnt_q != '0) && !load_i) |=> (cnt_q == $past(cnt_q) - SW_W'(1)));
endmodule

// File: rtl/rtc_events.sv
module rtc_events
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EV-1:0] evt_i,
  input  logic [NUM_EV-1:0] ien_i,
  input  logic              clr_i,
  input  logic [NUM_EV-1:0] clr_mask_i,
  output logic [NUM_EV-1:0] status_o,
  output logic              irq_o,
  output logic              wakeup_o
);
  logic [NUM_EV-1:0] status_q, status_d;
  logic              wake_q, wake_d;

  always_comb begin
    status_d = status_q;
    if (clr_i) status_d = status_d & ~clr_mask_i;
    status_d = status_d | evt_i;
    wake_d   = |(evt_i & ien_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      wake_q   <= 1'b0;
    end else begin
      status_q <= status_d;
      wake_q   <= wake_d;
    end
  end

  assign status_o = status_q;
  assign irq_o    = |(status_q & ien_i);
  assign wakeup_o = wake_q;

  // R8
  event_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> (|status_q));
  // R10
  wake_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_q |=> !wake_q);
endmodule

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper
  import rtc_pkg::*;
#(
  parameter int DIV   = 32768,
  parameter int DAY_W = 15,
  parameter int SW_W  = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [2:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic        irq,
  output logic        wakeup
);
  logic             time_wr, sw_wr, stat_wr;
  logic             tick;
  tod_t             tod, nxt_tod, wr_tod;
  logic [DAY_W-1:0] day, nxt_day, wr_day;
  logic [3:0]       roll;
  logic [SW_W-1:0]  sw_cnt;
  logic             sw_uf;
  logic [NUM_EV-1:0] evt, status;

  tod_t              al1_q, al1_d, al2_tod_q, al2_tod_d;
  logic [DAY_W-1:0]  al2_day_q, al2_day_d;
  logic [NUM_EV-1:0] ien_q, ien_d;

  assign time_wr = wr_en && (wr_addr == A_TIME);
  assign sw_wr   = wr_en && (wr_addr == A_SW);
  assign stat_wr = wr_en && (wr_addr == A_STAT);
  assign wr_tod  = tod_t'(wr_data[TOD_W-1:0]);
  assign wr_day  = wr_data[DAY_LSB +: DAY_W];

  rtc_prescaler #(.DIV(DIV)) u_presc (
    .clk(clk), .rst_n(rst_n), .restart_i(time_wr), .tick_o(tick)
  );

  rtc_time_counter #(.DAY_W(DAY_W)) u_time (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .load_i(time_wr),
    .load_tod_i(wr_tod), .load_day_i(wr_day),
    .tod_o(tod), .day_o(day), .nxt_tod_o(nxt_tod), .nxt_day_o(nxt_day),
    .roll_o(roll)
  );

  rtc_stopwatch #(.SW_W(SW_W)) u_sw (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .load_i(sw_wr),
    .load_val_i(wr_data[SW_W-1:0]), .cnt_o(sw_cnt), .underflow_o(sw_uf)
  );

  always_comb begin
    evt          = '0;
    evt[EV_DAY:EV_SEC] = roll;
    evt[EV_AL1]  = tick && (nxt_tod == al1_q);
    evt[EV_AL2]  = tick && (nxt_tod == al2_tod_q) && (nxt_day == al2_day_q);
    evt[EV_SW]   = sw_uf;
  end

  rtc_events u_evt (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .ien_i(ien_q),
    .clr_i(stat_wr), .clr_mask_i(wr_data[NUM_EV-1:0]),
    .status_o(status), .irq_o(irq), .wakeup_o(wakeup)
  );

  always_comb begin
    al1_d     = al1_q;
    al2_tod_d = al2_tod_q;
    al2_day_d = al2_day_q;
    ien_d     = ien_q;
    if (wr_en) begin
      case (wr_addr)
        A_AL1:   al1_d = tod_sanitize(wr_tod);
        A_AL2: begin
          al2_tod_d = tod_sanitize(wr_tod);
          al2_day_d = wr_day;
        end
        A_IEN:   ien_d = wr_data[NUM_EV-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      al1_q     <= '0;
      al2_tod_q <= '0;
      al2_day_q <= '0;
      ien_q     <= '0;
    end else begin
      al1_q     <= al1_d;
      al2_tod_q <= al2_tod_d;
      al2_day_q <= al2_day_d;
      ien_q     <= ien_d;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_TIME: begin
        rd_data[TOD_W-1:0]         = tod;
        rd_data[DAY_LSB +: DAY_W]  = day;
      end
      A_AL1:  rd_data[TOD_W-1:0] = al1_q;
      A_AL2: begin
        rd_data[TOD_W-1:0]         = al2_tod_q;
        rd_data[DAY_LSB +: DAY_W]  = al2_day_q;
      end
      A_SW:   rd_data[SW_W-1:0]   = sw_cnt;
      A_IEN:  rd_data[NUM_EV-1:0] = ien_q;
      A_STAT: rd_data[NUM_EV-1:0] = status;
      default: ;
    endcase
  end

  // R9
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status == '0) |-> !irq);
endmodule

// File: tb/tb_rtc_timekeeper.sv
module tb_rtc_timekeeper;
  localparam int P     = 4;
  localparam int DAYW  = 3;
  localparam int NDAYS = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq, wakeup;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  rtc_timekeeper #(.DIV(P), .DAY_W(DAYW), .SW_W(4)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .irq(irq), .wakeup(wakeup)
  );

  function automatic logic [31:0] tw(input int total);
    int t;
    t = total % (NDAYS * 86400);
    return (32'(t / 86400) << 17) | (32'((t % 86400) / 3600) << 12) |
           (32'((t % 3600) / 60) << 6) | 32'(t % 60);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      chk("R11 register zero", v, 32'd0);
    end
    chk("R11 irq low", {31'd0, irq}, 32'd0);
    chk("R11 wakeup low", {31'd0, wakeup}, 32'd0);

    // R1 R2 R4 R9 R10 sweep across midnight and day wrap
    base = 7 * 86400 + 23 * 3600 + 59 * 60 + 50;
    wr(3'd0, tw(base));
    wr(3'd5, 32'h7F);
    wr(3'd4, 32'h08);
    repeat (P - 2) @(negedge clk);
    for (int k = 0; k < 20; k++) begin
      if (k > 0) repeat (P) @(negedge clk);
      rd(3'd0, v);
      chk("R1 R2 time per second", v, tw(base + k));
      chk("R10 wakeup on day roll", {31'd0, wakeup}, {31'd0, (k == 10)});
      chk("R9 irq on enabled day flag", {31'd0, irq}, {31'd0, (k >= 10)});
      if (k == 5) begin
        rd(3'd5, v);
        chk("R4 only second flag before wrap", {28'd0, v[3:0]}, 32'h1);
      end
    end
    rd(3'd5, v);
    chk("R4 all rollover flags", {28'd0, v[3:0]}, 32'hF);
    @(negedge clk);
    chk("R10 wakeup one cycle", {31'd0, wakeup}, 32'd0);

    // R3 R5 R6 alarms, time now day0 00:00:09 with one edge gone
    wr(3'd0, tw(3 * 86400 + 10 * 3600 + 3));
    wr(3'd1, tw(10 * 3600 + 5));
    wr(3'd2, tw(5 * 86400 + 10 * 3600 + 5));
    wr(3'd4, 32'h0);
    rd(3'd0, v);
    chk("R3 old time before load", v, tw(9));
    wr(3'd5, 32'h7F);
    rd(3'd0, v);
    chk("R3 written time at load", v, tw(3 * 86400 + 10 * 3600 + 3));
    rd(3'd5, v);
    chk("R3 load raises no rollover", {28'd0, v[3:0]}, 32'h0);
    repeat (P) @(negedge clk);
    rd(3'd5, v);
    chk("R5 no alarm one second early", {30'd0, v[5:4]}, 32'h0);
    repeat (P) @(negedge clk);
    rd(3'd5, v);
    chk("R5 R6 daily fires dated not", {30'd0, v[5:4]}, 32'h1);
    chk("R9 irq masked when disabled", {31'd0, irq}, 32'd0);
    wr(3'd0, tw(5 * 86400 + 10 * 3600 + 3));
    wr(3'd5, 32'h7F);
    repeat (P + 2 * P - 1) @(negedge clk);
    rd(3'd5, v);
    chk("R6 dated alarm fires", {30'd0, v[5:4]}, 32'h3);

    // R7 R8 countdown
    wr(3'd0, tw(86400 + 3600));
    wr(3'd3, 32'd3);
    wr(3'd5, 32'h7F);
    wr(3'd4, 32'h40);
    repeat (3 * P - 3) @(negedge clk);
    rd(3'd3, v);
    chk("R7 countdown reached zero", v, 32'd0);
    rd(3'd5, v);
    chk("R7 no underflow yet", {31'd0, v[6]}, 32'd0);
    chk("R9 irq low before underflow", {31'd0, irq}, 32'd0);
    repeat (P) @(negedge clk);
    rd(3'd5, v);
    chk("R7 underflow flag", {31'd0, v[6]}, 32'd1);
    chk("R9 irq on underflow", {31'd0, irq}, 32'd1);
    chk("R10 wakeup on underflow", {31'd0, wakeup}, 32'd1);
    repeat (P) @(negedge clk);
    rd(3'd3, v);
    chk("R7 stays at zero", v, 32'd0);
    wr(3'd5, 32'h40);
    rd(3'd5, v);
    chk("R8 cleared bit gone", {31'd0, v[6]}, 32'd0);
    chk("R8 other bits kept", {31'd0, v[0]}, 32'd1);
    chk("R9 irq drops after clear", {31'd0, irq}, 32'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule